// File: doc/BRIEF.md
# Dual-Lane ADC Serial Read Controller

This block is the host-side master for the serial interface of an eight-channel, simultaneous-sampling converter. Each channel produces an 18-bit result. A start pulse begins a read. The block drives an active-low chip select and a serial clock derived from the system clock. It shifts in the converter's results, either from two data lanes in parallel or from a single lane. When the read is complete, it presents all eight results at once, indexed by channel number.

The block samples each data lane when it drives the serial clock low. Each result is built MSB first. When only lane B is wired, the converter delivers channels 5 to 8 first and then channels 1 to 4. The block undoes this rotation before it stores the results. A framing input selects one of two chip-select styles: held low for the whole read, or raised between every 18-bit word.

The converter's first-data flag is compared against the expected channel-1 window on every sample. Any mismatch is reported through an alignment-error output. An inhibit input holds a start request off, for example while the converter is updating its output registers.

Top module: `adc_serial_reader`

## Requirements
- R1: While reset is asserted, cs_no and sclk_o are high, done_o and align_err_o are low, and results_o is all zeros.
- R2: With lane_sel_i = 2'b00 (dual lane), a read drives 72 falling SCLK edges. The four words on dout_a_i become channels 1-4 and the four words on dout_b_i become channels 5-8. Channel k occupies results_o[(k-1)*18 +: 18].
- R3: With lane_sel_i = 2'b01 (lane A only), a read drives 144 falling SCLK edges, and the eight words on dout_a_i are stored as channels 1 to 8 in arrival order.
- R4: With lane_sel_i = 2'b10 (lane B only), a read drives 144 falling SCLK edges. The eight words on dout_b_i arrive as channels 5, 6, 7, 8, 1, 2, 3, 4, and each is stored in its own channel slot.
- R5: A data lane is sampled at each falling SCLK edge, and the first sample taken after chip select falls is bit 17 (MSB) of the word.
- R6: SCLK is high whenever chip select is high. The first falling SCLK edge of each chip-select frame comes at least DIV - DIV/2 system clocks after chip select falls.
- R7: With frame_pulse_i = 0, chip select stays low for the whole read. With frame_pulse_i = 1, chip select goes high between 18-bit words, which gives one frame per word: 4 frames in dual mode, 8 in single-lane mode.
- R8: first_i must be 1 on every sample of the first word and 0 on every other sample. align_err_o, updated with done_o, is 1 if any sample of that read broke this rule and 0 otherwise.
- R9: A start request made while inhibit_i is high is kept pending. Chip select does not fall until inhibit_i is sampled low.
- R10: done_o is a single-cycle pulse issued only after chip select has been high for at least one cycle. results_o changes only in the cycle in which done_o is high.
- R11: Within a frame, SCLK stays low for DIV/2 system clocks and high for DIV - DIV/2 system clocks, so consecutive falling edges are DIV clocks apart. DIV must be at least 2.
- R12: start_i is ignored while a read is in progress, so no extra chip-select frame follows done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start-of-read request pulse |
| inhibit_i | input | 1 | Holds a start request off while high |
| lane_sel_i | input | 2 | 00 dual lane, 01 lane A only, 10 lane B only (11 acts as 00) |
| frame_pulse_i | input | 1 | 0 holds chip select low for the whole read, 1 raises it between words |
| dout_a_i | input | 1 | Serial data lane A from the converter |
| dout_b_i | input | 1 | Serial data lane B from the converter |
| first_i | input | 1 | First-data flag from the converter |
| cs_no | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idles high |
| results_o | output | NUM_CH*DATA_W | Channel results, channel 1 in the low bits |
| done_o | output | 1 | One-cycle pulse when results_o has been updated |
| align_err_o | output | 1 | First-data flag mismatch seen in the last read |

## Verification
The bench models the converter. The model moves its data pointer on every rising SCLK edge while chip select is low, so a design that samples on the wrong edge, or that skips or adds a bit across a word boundary or a chip-select gap, lands on the wrong bits. MSB-first assembly is tested with asymmetric patterns such as 0x20003, which a reversed shift would turn into a different value. The lane-B rotation is exercised in both framing styles: an unmapped store puts channel 5 data in slot 1. The flag checker is tested with the flag dropped inside the first word and with the flag raised in a later word. The inhibit test and the start pulse issued mid-read catch a controller that launches early or restarts on its own.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [1:0] {
    LANES_DUAL  = 2'b00,
    LANE_A_ONLY = 2'b01,
    LANE_B_ONLY = 2'b10
  } lane_mode_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_ACTIVE,
    S_GAP,
    S_FIN
  } rd_state_e;

  function automatic lane_mode_e decode_lane_sel(input logic [1:0] sel);
    case (sel)
      2'b01:   return LANE_A_ONLY;
      2'b10:   return LANE_B_ONLY;
      default: return LANES_DUAL;
    endcase
  endfunction

endpackage

// File: rtl/adc_rd_sclk.sv
module adc_rd_sclk #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic fall_en_i,
  output logic sclk_o,
  output logic hi_end_o,
  output logic fall_o
);
  localparam int LO  = DIV / 2;
  localparam int HI  = DIV - LO;
  localparam int PHW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [PHW-1:0] ph_q;
  logic           sclk_q;

  assign hi_end_o = run_i && sclk_q && (ph_q == PHW'(HI - 1));
  assign fall_o   = hi_end_o && fall_en_i;
  assign sclk_o   = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      sclk_q <= 1'b1;
    end else if (!run_i) begin
      ph_q   <= '0;
      sclk_q <= 1'b1;
    end else if (sclk_q) begin
      if (ph_q == PHW'(HI - 1)) begin
        ph_q <= '0;
        if (fall_en_i) sclk_q <= 1'b0;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end else begin
      if (ph_q == PHW'(LO - 1)) begin
        ph_q   <= '0;
        sclk_q <= 1'b1;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_rd_lane.sv
module adc_rd_lane #(
  parameter int DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              din_i,
  output logic [DATA_W-1:0] word_o
);
  logic [DATA_W-2:0] sh_q;

  // word is complete on the sample that carries the LSB
  assign word_o = {sh_q, din_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (shift_i) sh_q <= {sh_q[DATA_W-3:0], din_i};
  end

endmodule

// File: rtl/adc_rd_store.sv
module adc_rd_store
  import adc_rd_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int NUM_CH = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  lane_mode_e                 mode_i,
  input  logic [$clog2(NUM_CH)-1:0]  word_idx_i,
  input  logic [DATA_W-1:0]          word_a_i,
  input  logic [DATA_W-1:0]          word_b_i,
  input  logic                       commit_i,
  output logic [NUM_CH*DATA_W-1:0]   results_o
);
  localparam int HALF = NUM_CH / 2;

  int widx;
  assign widx = int'(word_idx_i);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic              we;
    logic [DATA_W-1:0] wd;
    logic [DATA_W-1:0] stage_q;
    logic [DATA_W-1:0] res_q;

    always_comb begin
      we = 1'b0;
      wd = word_a_i;
      case (mode_i)
        LANE_A_ONLY: we = wr_i && (widx == c);
        LANE_B_ONLY: begin
          // lane B alone delivers the upper half first
          we = wr_i && (((widx + HALF) % NUM_CH) == c);
          wd = word_b_i;
        end
        default: begin
          if (widx == c) begin
            we = wr_i;
          end else if (widx + HALF == c) begin
            we = wr_i;
            wd = word_b_i;
          end
        end
      endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q <= '0;
        res_q   <= '0;
      end else begin
        if (we)       stage_q <= wd;
        if (commit_i) res_q   <= stage_q;
      end
    end

    assign results_o[c*DATA_W +: DATA_W] = res_q;
  end

endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader
  import adc_rd_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int NUM_CH = 8,
  parameter int DIV    = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     inhibit_i,
  input  logic [1:0]               lane_sel_i,
  input  logic                     frame_pulse_i,
  input  logic                     dout_a_i,
  input  logic                     dout_b_i,
  input  logic                     first_i,
  output logic                     cs_no,
  output logic                     sclk_o,
  output logic [NUM_CH*DATA_W-1:0] results_o,
  output logic                     done_o,
  output logic                     align_err_o
);
  localparam int WCW  = $clog2(NUM_CH);
  localparam int BCW  = $clog2(DATA_W + 1);
  localparam int GW   = $clog2(DIV + 1);
  localparam int HALF = NUM_CH / 2;

  if (DIV < 2) begin : g_bad_div
    $error("DIV must be at least 2");
  end

  rd_state_e  state_q;
  lane_mode_e mode_q;
  logic           pulse_q, pend_q, cs_q, err_q, done_q, align_q;
  logic [WCW-1:0] word_q;
  logic [BCW-1:0] bit_q;
  logic [GW-1:0]  gap_q;

  logic run, fall_en, fall, hi_end, word_full, word_last, exp_first, wr;
  logic [1:0]        lane_din;
  logic [DATA_W-1:0] lane_word [2];

  assign run       = (state_q == S_ACTIVE);
  assign word_full = (bit_q == BCW'(DATA_W));
  assign word_last = (mode_q == LANES_DUAL) ? (word_q == WCW'(HALF - 1))
                                            : (word_q == WCW'(NUM_CH - 1));
  assign fall_en   = !word_full || (!word_last && !pulse_q);
  assign exp_first = (word_q == '0) && !word_full;
  assign wr        = fall && (bit_q == BCW'(DATA_W - 1));
  assign lane_din  = {dout_b_i, dout_a_i};

  adc_rd_sclk #(.DIV(DIV)) u_sclk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .fall_en_i(fall_en),
    .sclk_o   (sclk_o),
    .hi_end_o (hi_end),
    .fall_o   (fall)
  );

  for (genvar l = 0; l < 2; l++) begin : g_lane
    adc_rd_lane #(.DATA_W(DATA_W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .shift_i(fall),
      .din_i  (lane_din[l]),
      .word_o (lane_word[l])
    );
  end

  adc_rd_store #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr),
    .mode_i    (mode_q),
    .word_idx_i(word_q),
    .word_a_i  (lane_word[0]),
    .word_b_i  (lane_word[1]),
    .commit_i  (state_q == S_FIN),
    .results_o (results_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      mode_q  <= LANES_DUAL;
      pulse_q <= 1'b0;
      pend_q  <= 1'b0;
      cs_q    <= 1'b1;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      align_q <= 1'b0;
      word_q  <= '0;
      bit_q   <= '0;
      gap_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start_i || pend_q) begin
            if (inhibit_i) begin
              pend_q <= 1'b1;
            end else begin
              pend_q  <= 1'b0;
              cs_q    <= 1'b0;
              mode_q  <= decode_lane_sel(lane_sel_i);
              pulse_q <= frame_pulse_i;
              word_q  <= '0;
              bit_q   <= '0;
              err_q   <= 1'b0;
              state_q <= S_ACTIVE;
            end
          end
        end
        S_ACTIVE: begin
          if (fall) begin
            if (first_i != exp_first) err_q <= 1'b1;
            if (word_full) begin
              bit_q  <= BCW'(1);
              word_q <= word_q + 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end else if (hi_end) begin
            cs_q    <= 1'b1;
            gap_q   <= '0;
            state_q <= word_last ? S_FIN : S_GAP;
          end
        end
        S_GAP: begin
          if (gap_q == GW'(DIV - 1)) begin
            cs_q    <= 1'b0;
            bit_q   <= '0;
            word_q  <= word_q + 1'b1;
            state_q <= S_ACTIVE;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        default: begin
          done_q  <= 1'b1;
          align_q <= err_q;
          state_q <= S_IDLE;
        end
      endcase
    end
  end

  assign cs_no       = cs_q;
  assign done_o      = done_q;
  assign align_err_o = align_q;

endmodule

// File: rtl/adc_rd_chk.sv
module adc_rd_chk #(
  parameter int DIV = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic sclk_i,
  input logic done_i,
  input logic inhibit_i
);
  localparam int LO = DIV / 2;
  localparam int HI = DIV - LO;
  localparam int CW = $clog2(DIV + 2) + 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] lo_cnt, hi_cnt;
  logic          reading_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt    <= '0;
      hi_cnt    <= '0;
      reading_q <= 1'b0;
    end else begin
      lo_cnt <= sclk_i ? '0 : ((lo_cnt == CMAX) ? lo_cnt : lo_cnt + 1'b1);
      hi_cnt <= (!sclk_i || cs_ni) ? '0 : ((hi_cnt == CMAX) ? hi_cnt : hi_cnt + 1'b1);
      if (done_i)      reading_q <= 1'b0;
      else if (!cs_ni) reading_q <= 1'b1;
    end
  end

  // R6
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> sclk_i);

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  // R10
  done_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (cs_ni && $past(cs_ni)));

  // R9
  inhibit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reading_q && $fell(cs_ni)) |-> !$past(inhibit_i));

  // R11
  low_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_i) |-> (lo_cnt == CW'(LO)));

  // R11
  high_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_i) |-> (hi_cnt == CW'(HI)));

endmodule

bind adc_serial_reader adc_rd_chk #(.DIV(DIV)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_ni    (cs_no),
  .sclk_i   (sclk_o),
  .done_i   (done_o),
  .inhibit_i(inhibit_i)
);

// File: tb/adc_serial_reader_test.sv
module adc_serial_reader_test;
  localparam int DW  = 18;
  localparam int NCH = 8;
  localparam int DIV = 4;
  localparam int HI  = DIV - DIV / 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, inhibit = 1'b0, frame_pulse = 1'b0;
  logic [1:0] lane_sel = 2'b00;
  logic dout_a = 1'b0, dout_b = 1'b0, first = 1'b0;
  logic cs_no, sclk_o, done_o, align_err_o;
  logic [NCH*DW-1:0] results_o;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  adc_serial_reader #(.DATA_W(DW), .NUM_CH(NCH), .DIV(DIV)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .inhibit_i(inhibit),
    .lane_sel_i(lane_sel), .frame_pulse_i(frame_pulse),
    .dout_a_i(dout_a), .dout_b_i(dout_b), .first_i(first),
    .cs_no(cs_no), .sclk_o(sclk_o), .results_o(results_o),
    .done_o(done_o), .align_err_o(align_err_o)
  );

  // converter model
  logic [DW-1:0] ch_val [NCH];
  int gidx = 0, cur_mode = 0, err_at = -1, refresh = 0;

  function automatic logic stream_bit(int lane, int idx);
    int w, b, ch;
    w = idx / DW;
    b = DW - 1 - (idx % DW);
    if (cur_mode == 0) begin
      if (w >= NCH / 2) return 1'b0;
      ch = (lane == 0) ? w : w + NCH / 2;
    end else begin
      if (w >= NCH) return 1'b0;
      ch = (lane == 0) ? w : (w + NCH / 2) % NCH;
    end
    return ch_val[ch][b];
  endfunction

  always @(posedge sclk_o) if (cs_no == 1'b0) gidx = gidx + 1;

  always @(gidx or refresh) begin
    dout_a = stream_bit(0, gidx);
    dout_b = stream_bit(1, gidx);
    first  = (gidx < DW) ^ (gidx == err_at);
  end

  // port monitor
  int cyc = 0, last_fall = 0, since_cs = 0;
  int falls, frames, dones, idle_err, delay_err, per_err, dsync_err, res_err;
  bit wait_first = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b1, prev_done = 1'b0;
  logic [NCH*DW-1:0] prev_res = '0;

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (cs_no && !sclk_o) idle_err++;
    if (prev_cs && !cs_no) begin
      frames++; since_cs = 0; wait_first = 1;
    end else if (!cs_no) since_cs++;
    if (prev_sclk && !sclk_o) begin
      falls++;
      if (wait_first) begin
        if (since_cs < HI) delay_err++;
        wait_first = 0;
      end else if (cyc - last_fall != DIV) per_err++;
      last_fall = cyc;
    end
    if (done_o) begin
      dones++;
      if (!(cs_no && prev_cs) || prev_done) dsync_err++;
    end
    if (results_o != prev_res && !done_o) res_err++;
    prev_cs = cs_no; prev_sclk = sclk_o; prev_done = done_o; prev_res = results_o;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_read(input int mode, input bit pulse, input int eat,
                          input int inh, input bit extra_start);
    string rq;
    int exp_falls, exp_frames, n;
    cur_mode = mode; err_at = eat; gidx = 0; refresh++;
    @(posedge clk);
    falls = 0; frames = 0; dones = 0; idle_err = 0; delay_err = 0;
    per_err = 0; dsync_err = 0; res_err = 0;
    @(negedge clk);
    lane_sel = 2'(mode); frame_pulse = pulse;
    if (inh > 0) inhibit = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (inh > 0) begin
      repeat (inh) @(negedge clk);
      // R9: pending start must not open a frame
      chk(frames == 0 && cs_no, "R9", "frames under inhibit", frames, 0);
      inhibit = 1'b0;
    end
    n = 0;
    while (!done_o) begin
      @(negedge clk);
      start = (extra_start && n == 60);
      n++;
    end
    start = 1'b0;
    rq = (mode == 0) ? "R2 R5" : (mode == 1) ? "R3 R5" : "R4 R5";
    for (int c = 0; c < NCH; c++)
      chk(results_o[c*DW +: DW] == ch_val[c], rq, $sformatf("channel %0d", c + 1),
          results_o[c*DW +: DW], ch_val[c]);
    chk(align_err_o == (eat >= 0), "R8", "align_err_o", align_err_o, eat >= 0);
    repeat (30) @(negedge clk);
    exp_falls  = (mode == 0) ? 72 : 144;
    exp_frames = pulse ? ((mode == 0) ? 4 : 8) : 1;
    chk(falls == exp_falls, (mode == 0) ? "R2" : "R3", "falling edges", falls, exp_falls);
    chk(frames == exp_frames, extra_start ? "R7 R12" : "R7", "cs frames", frames, exp_frames);
    chk(idle_err == 0 && delay_err == 0, "R6", "idle/setup violations",
        idle_err + delay_err, 0);
    chk(per_err == 0, "R11", "sclk period violations", per_err, 0);
    chk(dones == 1 && dsync_err == 0 && res_err == 0, "R10", "done/result timing",
        dones * 100 + dsync_err + res_err, 100);
  endtask

  task automatic set_vals(input logic [DW-1:0] base);
    for (int c = 0; c < NCH; c++) ch_val[c] = base ^ DW'(c * 18'h0924b);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int c = 0; c < NCH; c++) ch_val[c] = '0;
    repeat (3) @(negedge clk);
    // R1
    chk(cs_no == 1'b1 && sclk_o == 1'b1, "R1", "cs/sclk in reset", {cs_no, sclk_o}, 2'b11);
    chk(done_o == 1'b0 && align_err_o == 1'b0, "R1", "done/err in reset",
        {done_o, align_err_o}, 0);
    chk(results_o == '0, "R1", "results in reset", results_o[63:0], 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R5: asymmetric patterns expose bit reversal
    ch_val[0] = 18'h20003; ch_val[1] = 18'h3ffff; ch_val[2] = 18'h00000;
    ch_val[3] = 18'h2aaaa; ch_val[4] = 18'h15555; ch_val[5] = 18'h20000;
    ch_val[6] = 18'h00001; ch_val[7] = 18'h1c0f3;
    run_read(0, 1'b0, -1, 0, 1'b0);   // R2
    run_read(1, 1'b0, -1, 0, 1'b0);   // R3
    run_read(2, 1'b0, -1, 0, 1'b0);   // R4
    set_vals(18'h3c5a1);
    run_read(0, 1'b1, -1, 0, 1'b0);   // R7 dual pulsed
    run_read(2, 1'b1, -1, 0, 1'b0);   // R4 R7 lane B pulsed
    run_read(1, 1'b1, -1, 0, 1'b0);
    run_read(0, 1'b0, 5, 0, 1'b0);    // R8 flag low inside first word
    run_read(1, 1'b0, 40, 0, 1'b0);   // R8 flag high in a later word
    run_read(2, 1'b1, 17, 0, 1'b0);   // R8 last bit of first word
    run_read(0, 1'b0, -1, 0, 1'b0);   // R8 error clears on clean read
    run_read(1, 1'b0, -1, 60, 1'b0);  // R9
    run_read(2, 1'b0, -1, 0, 1'b1);   // R12

    for (int i = 0; i < 24; i++) begin
      int m, e;
      for (int c = 0; c < NCH; c++) ch_val[c] = DW'($urandom());
      m = $urandom_range(2, 0);
      e = ($urandom_range(3, 0) == 0) ? $urandom_range((m == 0) ? 71 : 143, 0) : -1;
      run_read(m, 1'($urandom_range(1, 0)), e,
               ($urandom_range(3, 0) == 0) ? $urandom_range(20, 1) : 0,
               1'($urandom_range(1, 0)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule